// File: doc/BRIEF.md
# Phase Lock Detector

This block decides when a phase-locked loop has settled. It runs on a fast sampling clock and takes two single-bit inputs that are already synchronous to it: the reference clock and the divided feedback clock. On every rising edge of either input it measures how many sampling ticks separate the reference edge from its matching feedback edge. That signed phase error is checked against a tolerance window given in ticks.

A run of in-window reference cycles is counted. When the run reaches a programmed length the lock output rises. Any cycle that is out of window, or any reference cycle that has no feedback edge, clears the run and drops lock in the same clock. The signed error and a direction flag are also presented, together with a one-cycle valid strobe. A positive error means the feedback lags, so the oscillator must speed up. A negative error means the feedback leads, so the oscillator must slow down.

Top module: `phase_lock_monitor`

## Requirements
- R1: The error magnitude is the number of sampling ticks between the reference rising edge and the paired feedback rising edge. Both outputs `phaseErr` and `errValid` update on the clock edge that samples the later of the two rising edges. Rising edges that arrive in the same sample pair with each other and give an error of 0.
- R2: When the reference edge comes first (feedback lags), `phaseErr` is positive and `fbLags` is 1. When the feedback edge comes first (feedback leads), `phaseErr` is negative and `fbLags` is 0. When the error is 0, `fbLags` is 0.
- R3: A pairing is in window when |error| <= WINDOW. A pairing with |error| = WINDOW counts as good; a pairing with |error| = WINDOW+1 counts as bad.
- R4: `lockOut` rises on the same clock edge that records the LOCK_CYCLES-th consecutive good pairing, and not on any earlier edge.
- R5: An out-of-window pairing clears the run count and drops `lockOut` on the clock edge that records that pairing.
- R6: A second reference rising edge that arrives while an earlier reference edge still waits for its feedback edge counts as a bad cycle. This also applies when the second reference edge coincides with a feedback edge. Such a bad cycle pulses no `errValid`.
- R7: The run count saturates at LOCK_CYCLES, so further good pairings keep `lockOut` high.
- R8: While `rstN` is low at a clock edge, that edge clears lock, run count, error, direction flag, valid strobe and any pending edge. After reset, a lone feedback edge produces no verdict.
- R9: A second feedback rising edge with no reference edge in between restarts the lead measurement from the newer feedback edge, without a verdict.
- R10: The tick counter saturates at MAX_TICKS. A separation longer than MAX_TICKS reports a magnitude of exactly MAX_TICKS and is judged out of window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Synchronous reset, active low |
| refIn | input | 1 | Synchronized reference clock |
| fbIn | input | 1 | Synchronized feedback clock |
| lockOut | output | 1 | Lock indication |
| phaseErr | output | $clog2(MAX_TICKS+1)+1 | Last signed phase error in ticks (positive = feedback lags) |
| fbLags | output | 1 | 1 when the last error shows the feedback lagging |
| errValid | output | 1 | One-cycle pulse when `phaseErr` is updated |

## Verification
The bench builds the block with LOCK_CYCLES=4, WINDOW=2 and MAX_TICKS=15, and uses a 40-tick reference period. A run length of 4 makes it cheap to watch lock build, saturate, break and rebuild several times. A window of 2 places both edges of the tolerance, ±2 and ±3, one tick apart. A tick limit of 15 lets a 20-tick lag show counter saturation within one reference period. Missing feedback edges, doubled feedback edges and a reset taken while a reference edge is still pending are each driven as their own directed pattern.

// File: rtl/lock_detect_pkg.sv
package lock_detect_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_REF_WAIT = 2'd1,
    ST_FB_WAIT  = 2'd2
  } pairState_t;

  typedef struct packed {
    logic loadTick;
    logic capture;
    logic lagDir;
    logic zeroErr;
  } dpCtrl_t;

endpackage

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_detect_pkg::*;
#(
  parameter int WINDOW    = 2,
  parameter int MAX_TICKS = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  input  logic fbIn,
  input  dpCtrl_t ctrl,
  output logic refRise,
  output logic fbRise,
  output logic inWindow,
  output logic signed [$clog2(MAX_TICKS+1):0] phaseErr,
  output logic fbLags,
  output logic errValid
);
  localparam int TICK_W = $clog2(MAX_TICKS + 1);
  localparam int ERR_W  = TICK_W + 1;
  localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(MAX_TICKS);
  localparam logic [TICK_W-1:0] WIN_T    = TICK_W'(WINDOW);

  logic refPrev, fbPrev;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] magNow;
  logic [ERR_W-1:0]  magExt;

  assign refRise = refIn & ~refPrev;
  assign fbRise  = fbIn & ~fbPrev;

  assign magNow   = ctrl.zeroErr ? '0 : tickCnt;
  assign magExt   = {1'b0, magNow};
  assign inWindow = (magNow <= WIN_T);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      fbPrev  <= 1'b0;
      tickCnt <= '0;
    end else begin
      refPrev <= refIn;
      fbPrev  <= fbIn;
      if (ctrl.loadTick) begin
        tickCnt <= TICK_W'(1);
      end else if (tickCnt != TICK_MAX) begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseErr <= '0;
      fbLags   <= 1'b0;
      errValid <= 1'b0;
    end else begin
      errValid <= ctrl.capture;
      if (ctrl.capture) begin
        phaseErr <= ctrl.lagDir ? magExt : (ERR_W'(0) - magExt);
        fbLags   <= ctrl.lagDir & (magNow != '0);
      end
    end
  end

endmodule

// File: rtl/lock_control.sv
module lock_control
  import lock_detect_pkg::*;
#(
  parameter int LOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refRise,
  input  logic fbRise,
  input  logic inWindow,
  output dpCtrl_t ctrl,
  output logic evalGood,
  output logic evalBad,
  output logic [$clog2(LOCK_CYCLES+1)-1:0] consecCnt,
  output logic lockOut
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LOCK_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

  pairState_t state, stateNext;
  logic missedFb;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    missedFb  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (refRise && fbRise) begin
          ctrl.capture = 1'b1;
          ctrl.zeroErr = 1'b1;
        end else if (refRise) begin
          ctrl.loadTick = 1'b1;
          stateNext     = ST_REF_WAIT;
        end else if (fbRise) begin
          ctrl.loadTick = 1'b1;
          stateNext     = ST_FB_WAIT;
        end
      end
      ST_REF_WAIT: begin
        if (refRise) begin
          missedFb = 1'b1;
          if (fbRise) begin
            stateNext = ST_IDLE;
          end else begin
            ctrl.loadTick = 1'b1;
          end
        end else if (fbRise) begin
          ctrl.capture = 1'b1;
          ctrl.lagDir  = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      ST_FB_WAIT: begin
        if (refRise) begin
          ctrl.capture = 1'b1;
          ctrl.zeroErr = fbRise;
          stateNext    = ST_IDLE;
        end else if (fbRise) begin
          ctrl.loadTick = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign evalGood = ctrl.capture & inWindow;
  assign evalBad  = (ctrl.capture & ~inWindow) | missedFb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      consecCnt <= '0;
      lockOut   <= 1'b0;
    end else begin
      state <= stateNext;
      if (evalBad) begin
        consecCnt <= '0;
        lockOut   <= 1'b0;
      end else if (evalGood) begin
        if (consecCnt != CNT_FULL) consecCnt <= consecCnt + 1'b1;
        if (consecCnt >= CNT_LAST) lockOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
  import lock_detect_pkg::*;
#(
  parameter int LOCK_CYCLES = 4,
  parameter int WINDOW      = 2,
  parameter int MAX_TICKS   = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  input  logic fbIn,
  output logic lockOut,
  output logic signed [$clog2(MAX_TICKS+1):0] phaseErr,
  output logic fbLags,
  output logic errValid
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  dpCtrl_t dpCtrl;
  logic refRise, fbRise, inWindow;
  logic evalGood, evalBad;
  logic [CNT_W-1:0] consecCnt;

  lock_datapath #(
    .WINDOW   (WINDOW),
    .MAX_TICKS(MAX_TICKS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .refIn   (refIn),
    .fbIn    (fbIn),
    .ctrl    (dpCtrl),
    .refRise (refRise),
    .fbRise  (fbRise),
    .inWindow(inWindow),
    .phaseErr(phaseErr),
    .fbLags  (fbLags),
    .errValid(errValid)
  );

  lock_control #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .refRise  (refRise),
    .fbRise   (fbRise),
    .inWindow (inWindow),
    .ctrl     (dpCtrl),
    .evalGood (evalGood),
    .evalBad  (evalBad),
    .consecCnt(consecCnt),
    .lockOut  (lockOut)
  );

endmodule

// File: rtl/phase_lock_checker.sv
module phase_lock_checker #(
  parameter int LOCK_CYCLES = 4,
  parameter int MAX_TICKS   = 15
) (
  input logic clk,
  input logic rstN,
  input logic lockOut,
  input logic signed [$clog2(MAX_TICKS+1):0] phaseErr,
  input logic fbLags,
  input logic errValid,
  input logic evalGood,
  input logic evalBad,
  input logic [$clog2(LOCK_CYCLES+1)-1:0] consecCnt
);
  localparam int ERR_W = $clog2(MAX_TICKS + 1) + 1;
  localparam logic signed [ERR_W-1:0] ERR_MAX = ERR_W'(MAX_TICKS);

  p_reset_r8: assert property (@(posedge clk)
    !rstN |=> (!lockOut && !errValid && !fbLags && consecCnt == '0));

  p_bad_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    evalBad |=> (!lockOut && consecCnt == '0));

  p_rise_needs_good_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> $past(evalGood));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && evalGood) |=> lockOut);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    consecCnt <= ($clog2(LOCK_CYCLES+1))'(LOCK_CYCLES));

  p_sign_lag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && fbLags) |-> (phaseErr > 0));

  p_sign_lead_r2: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !fbLags) |-> (phaseErr <= 0));

  p_err_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (phaseErr <= ERR_MAX && phaseErr >= -ERR_MAX));

  p_one_verdict_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(evalGood && evalBad));

endmodule

bind phase_lock_monitor phase_lock_checker #(
  .LOCK_CYCLES(LOCK_CYCLES),
  .MAX_TICKS  (MAX_TICKS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lockOut  (lockOut),
  .phaseErr (phaseErr),
  .fbLags   (fbLags),
  .errValid (errValid),
  .evalGood (evalGood),
  .evalBad  (evalBad),
  .consecCnt(consecCnt)
);

// File: tb/phase_lock_monitor_test.sv
`timescale 1ns/1ps
module phase_lock_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_LOCK = 4;
  localparam int WIN    = 2;
  localparam int TMAX   = 15;
  localparam int PER    = 40;
  localparam int REF_AT = 10;
  localparam int ERR_W  = $clog2(TMAX + 1) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0;
  logic fbIn = 1'b0;
  logic lockOut, fbLags, errValid;
  logic signed [ERR_W-1:0] phaseErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int vCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_lock_monitor #(
    .LOCK_CYCLES(N_LOCK),
    .WINDOW     (WIN),
    .MAX_TICKS  (TMAX)
  ) uut (
    .clk     (clk),
    .rstN    (rstN),
    .refIn   (refIn),
    .fbIn    (fbIn),
    .lockOut (lockOut),
    .phaseErr(phaseErr),
    .fbLags  (fbLags),
    .errValid(errValid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One reference period: 2-tick pulses; negative start disables a pulse.
  task automatic runPattern(input int refAt, input int fb1, input int fb2);
    vCnt = 0;
    for (int k = 0; k < PER; k++) begin
      @(negedge clk);
      if (errValid) vCnt++;
      refIn = (refAt >= 0) && (k >= refAt) && (k < refAt + 2);
      fbIn  = ((fb1 >= 0) && (k >= fb1) && (k < fb1 + 2)) ||
              ((fb2 >= 0) && (k >= fb2) && (k < fb2 + 2));
    end
  endtask

  task automatic goodCycle(input int off, input int expLock, input string tag);
    runPattern(REF_AT, REF_AT + off, -1);
    check({tag, " errValid pulses"}, vCnt, 1);
    check({tag, " phaseErr"}, int'(phaseErr), off);
    check({tag, " fbLags"}, int'(fbLags), (off > 0) ? 1 : 0);
    check({tag, " lockOut"}, int'(lockOut), expLock);
  endtask

  task automatic doReset();
    rstN = 1'b0; refIn = 1'b0; fbIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 lockOut in reset", int'(lockOut), 0);
    check("R8 phaseErr in reset", int'(phaseErr), 0);
    check("R8 fbLags in reset", int'(fbLags), 0);
    check("R8 errValid in reset", int'(errValid), 0);
    rstN = 1'b1;
  endtask

  task automatic testLockBuild();
    goodCycle(0,  0, "R1 coincident");
    goodCycle(1,  0, "R2 lag by 1");
    goodCycle(-1, 0, "R2 lead by 1");
    goodCycle(2,  1, "R4 fourth good, R3 edge +2");
  endtask

  task automatic testSaturate();
    goodCycle(-2, 1, "R7 saturate 1, R3 edge -2");
    goodCycle(-2, 1, "R7 saturate 2");
    goodCycle(1,  1, "R7 saturate 3");
  endtask

  task automatic testBadWindow();
    goodCycle(3,  0, "R5 lag 3 out of window R3");
    goodCycle(-3, 0, "R5 lead 3 out of window R3");
    goodCycle(0,  0, "R4 rebuild 1");
    goodCycle(1,  0, "R4 rebuild 2");
    goodCycle(-1, 0, "R4 rebuild 3");
    goodCycle(0,  1, "R4 rebuild 4");
  endtask

  task automatic testMissingFb();
    runPattern(REF_AT, -1, -1);
    check("R6 no pulse without fb", vCnt, 0);
    check("R6 lock before verdict", int'(lockOut), 1);
    goodCycle(1, 0, "R6 second ref cleared run");
    goodCycle(1, 0, "R6 run 2");
    goodCycle(1, 0, "R6 run 3");
    goodCycle(1, 1, "R6 run 4");
  endtask

  task automatic testDoubleFb();
    runPattern(REF_AT, 4, 8);
    check("R9 single pulse", vCnt, 1);
    check("R9 error from newer fb", int'(phaseErr), -2);
    check("R9 fbLags", int'(fbLags), 0);
    check("R9 lock kept", int'(lockOut), 1);
  endtask

  task automatic testTickSat();
    runPattern(REF_AT, REF_AT + 20, -1);
    check("R10 pulse", vCnt, 1);
    check("R10 saturated magnitude", int'(phaseErr), TMAX);
    check("R10 fbLags", int'(fbLags), 1);
    check("R10 lock dropped", int'(lockOut), 0);
  endtask

  task automatic testResetPending();
    goodCycle(0, 0, "R8 prep 1");
    goodCycle(0, 0, "R8 prep 2");
    goodCycle(0, 0, "R8 prep 3");
    goodCycle(0, 1, "R8 prep 4");
    runPattern(REF_AT, -1, -1);
    doReset();
    runPattern(-1, 20, -1);
    check("R8 pending ref cleared", vCnt, 0);
    check("R8 lock stays low", int'(lockOut), 0);
    check("R8 error unchanged", int'(phaseErr), 0);
  endtask

  initial begin
    doReset();
    testLockBuild();
    testSaturate();
    testBadWindow();
    testMissingFb();
    testDoubleFb();
    testTickSat();
    testResetPending();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule